// File: doc/BRIEF.md
# Sampling Converter Serial Port with Power States

This block is the digital half of a four-channel, 12-bit sampling converter as a host sees it across its serial port. The host lowers chip select to begin a frame and gives sixteen serial clocks. On the first twelve falling clock edges the block takes in a control word. On every falling edge it moves its tagged result one bit further out. The result comes from a per-channel sample bus, captured at the moment chip select falls. That moment is also when the track-and-hold indicator goes to hold.

The control register holds a write enable, a two-bit power code and a channel address. It changes only at the end of a full sixteen-edge frame, and only when the write enable in that word is set. Three power behaviours are decoded from the register. Normal mode keeps the block powered. Full shutdown sleeps until a write restores normal mode, and the output floats during that wake-up frame. Auto shutdown sleeps after every valid conversion and wakes at the next frame start. Wake-up takes a parameterised number of system clocks. A frame that starts before wake-up is complete reports an all-zero result and raises a stale flag.

The serial pins are sampled with the system clock, so the serial clock must run well below the system clock.

Top module: `sar_adc_port`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `dout_oe` is 0, `track` is 1 and `stale` is 0. The control register resets to normal mode (power code 11) with channel 0, so the block starts powered.
- R2: A frame returns 16 bits, most significant first. The frame is two zeros, then the 2-bit channel address held in the control register when `cs_n` fell, then the 12-bit sample of that channel captured at that fall. Bit 0 of the frame is on `dout` one system clock after `cs_n` falls. Each later bit appears one system clock after each falling `sclk` edge.
- R3: `din` is taken on the first 12 falling `sclk` edges of a frame, most significant bit first, to form a control word. Bit 11 is the write enable, bits 10:9 are the power code and bits 8:7 are the channel address. The word is loaded into the control register on the 16th falling edge when bit 11 is 1.
- R4: A complete frame whose bit 11 is 0 leaves the control register unchanged, including the power code.
- R5: If `cs_n` rises before the 16th falling `sclk` edge, the control register is not updated. The next frame starts counting from its first edge.
- R6: `track` goes to 0 one system clock after `cs_n` falls. It returns to 1 one system clock after the 14th falling `sclk` edge of the frame.
- R7: After a complete frame that leaves power code 10 in the register, the block sleeps and `track` is 0. A frame that starts while asleep in this mode keeps `dout_oe` at 0 throughout.
- R8: A complete frame that writes power code 11 while the block sleeps starts a wake-up of WAKE_CYC system clocks at the rise of `cs_n`. A frame begun before wake-up ends is stale and returns zero sample bits. A frame begun after wake-up ends is valid.
- R9: With power code 01, a complete valid frame puts the block to sleep at the rise of `cs_n`, and `track` is then 0. The next `cs_n` fall starts wake-up. That frame drives `dout`, is stale, returns zero sample bits and leaves the block awake.
- R10: `dout_oe` is 0 one system clock after `cs_n` rises and stays 0 while `cs_n` stays high.
- R11: `stale` is updated only at a `cs_n` fall. It is 1 when the frame began before the block was fully powered and 0 otherwise. It holds that value until the next fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; a fall starts a frame |
| sclk | input | 1 | Serial clock, idles high; falling edges step the frame |
| din | input | 1 | Serial control data from the host |
| samples | input | NCH*RES | Per-channel samples, channel k in bits k*RES +: RES |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means the pin floats |
| track | output | 1 | 1 when the track-and-hold tracks, 0 when it holds |
| stale | output | 1 | 1 when the last frame began before wake-up had finished |

## Verification
The bench builds the block with RES = 12 and NCH = 4 and shortens WAKE_CYC to 24. With that value, a frame that follows a wake-up event within a few clocks lands inside the wake-up window. A frame that follows after a longer pause lands clear of it. This exercises both the stale and the valid outcome of R8 and R9 in a short run. Because a frame is much longer than 24 clocks, the first frame after an auto-mode wake-up is valid, and that frame puts the block back to sleep.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PS_ON   = 2'd0,
    PS_OFF  = 2'd1,
    PS_WAKE = 2'd2
  } pstate_t;

  localparam logic [1:0] PM_NORMAL = 2'b11;
  localparam logic [1:0] PM_FULL   = 2'b10;
  localparam logic [1:0] PM_AUTO   = 2'b01;
endpackage

// File: rtl/sar_frame.sv
module sar_frame #(
  parameter int CTLW = 12,
  parameter int FRM  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            din,
  output logic            cs_fall,
  output logic            cs_rise,
  output logic            frame_full,
  output logic            sclk_fall,
  output logic            track_edge,
  output logic            commit,
  output logic [CTLW-1:0] ctl_word
);
  localparam int CW = $clog2(FRM + 1);
  localparam logic [CW-1:0] N_FULL  = CW'(FRM);
  localparam logic [CW-1:0] N_LAST  = CW'(FRM - 1);
  localparam logic [CW-1:0] N_TRACK = CW'(FRM - 3);
  localparam logic [CW-1:0] N_CTL   = CW'(CTLW);

  logic          cs_d, sclk_d, act;
  logic [CW-1:0] cnt;
  logic [CTLW-1:0] sh;

  assign cs_fall    = cs_d & ~cs_n;
  assign cs_rise    = act & cs_n;
  assign frame_full = (cnt == N_FULL);
  assign sclk_fall  = act & ~cs_n & sclk_d & ~sclk;
  assign track_edge = sclk_fall && (cnt == N_TRACK);
  assign commit     = sclk_fall && (cnt == N_LAST) && sh[CTLW-1];
  assign ctl_word   = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b1;
      act    <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      cs_d   <= cs_n;
      sclk_d <= sclk;
      if (cs_fall) begin
        act <= 1'b1;
        cnt <= '0;
      end else if (cs_rise) begin
        act <= 1'b0;
        cnt <= '0;
      end else if (sclk_fall && cnt != N_FULL) begin
        cnt <= cnt + 1'b1;
        if (cnt < N_CTL) sh <= {sh[CTLW-2:0], din};
      end
    end
  end
endmodule

// File: rtl/sar_power.sv
module sar_power
  import sar_pkg::*;
#(
  parameter int WAKE_CYC = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_fall,
  input  logic       cs_end,
  input  logic       last_ok,
  input  logic [1:0] pm,
  output pstate_t    st,
  output logic       sleep
);
  localparam int WW = $clog2(WAKE_CYC + 1) + 1;
  localparam logic [WW-1:0] W_LOAD = WW'(WAKE_CYC - 1);

  pstate_t       nxt;
  logic [WW-1:0] wcnt;

  always_comb begin
    nxt = st;
    if (cs_fall && st == PS_OFF && pm == PM_AUTO) begin
      nxt = PS_WAKE;
    end else if (cs_end) begin
      case (pm)
        PM_FULL: nxt = PS_OFF;
        PM_AUTO: if (last_ok) nxt = PS_OFF;
        default: if (st == PS_OFF) nxt = PS_WAKE;
      endcase
    end else if (st == PS_WAKE && wcnt == '0) begin
      nxt = PS_ON;
    end
  end

  assign sleep = cs_end && (nxt == PS_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PS_ON;
      wcnt <= '0;
    end else begin
      st <= nxt;
      if (nxt == PS_WAKE && st != PS_WAKE) wcnt <= W_LOAD;
      else if (st == PS_WAKE && wcnt != '0) wcnt <= wcnt - 1'b1;
    end
  end
endmodule

// File: rtl/sar_dout.sv
module sar_dout #(
  parameter int FRM = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           shift,
  input  logic           drive,
  input  logic           stop,
  input  logic [FRM-1:0] word,
  output logic           dout,
  output logic           dout_oe
);
  logic [FRM-1:0] sreg;

  assign dout = sreg[FRM-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      dout_oe <= 1'b0;
    end else if (load) begin
      sreg    <= word;
      dout_oe <= drive;
    end else if (stop) begin
      dout_oe <= 1'b0;
    end else if (shift) begin
      sreg <= {sreg[FRM-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sar_adc_port.sv
module sar_adc_port
  import sar_pkg::*;
#(
  parameter int RES      = 12,
  parameter int NCH      = 4,
  parameter int WAKE_CYC = 250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  input  logic [NCH*RES-1:0] samples,
  output logic               dout,
  output logic               dout_oe,
  output logic               track,
  output logic               stale
);
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int FRM   = 2 + CHW + RES;
  localparam int CTLW  = RES;
  localparam int WR_B  = CTLW - 1;
  localparam int PM_HI = CTLW - 2;
  localparam int PM_LO = CTLW - 3;
  localparam int CH_HI = CTLW - 4;
  localparam int CH_LO = CH_HI - CHW + 1;

  logic            cs_fall, cs_rise, frame_full, sclk_fall, track_edge, commit;
  logic [CTLW-1:0] ctl_word, ctrl;
  logic [1:0]      pm;
  logic [CHW-1:0]  ch;
  logic [RES-1:0]  samp_sel;
  logic [FRM-1:0]  word;
  logic            conv_ok, float_frm, sleep;
  logic            ctrl_unused;
  pstate_t         st;

  assign pm          = ctrl[PM_HI:PM_LO];
  assign ch          = ctrl[CH_HI:CH_LO];
  assign ctrl_unused = ^{ctrl[WR_B], ctrl[CH_LO-1:0]};
  assign samp_sel    = samples[int'(ch)*RES +: RES];
  assign conv_ok     = (st == PS_ON);
  assign float_frm   = (st == PS_OFF) && (pm != PM_AUTO);
  assign word        = {2'b00, ch, conv_ok ? samp_sel : {RES{1'b0}}};

  sar_frame #(.CTLW(CTLW), .FRM(FRM)) u_frm (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .frame_full(frame_full),
    .sclk_fall(sclk_fall), .track_edge(track_edge), .commit(commit),
    .ctl_word(ctl_word)
  );

  sar_power #(.WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_end(cs_rise & frame_full),
    .last_ok(~stale), .pm(pm), .st(st), .sleep(sleep)
  );

  sar_dout #(.FRM(FRM)) u_out (
    .clk(clk), .rst(rst), .load(cs_fall), .shift(sclk_fall),
    .drive(~float_frm), .stop(cs_rise), .word(word),
    .dout(dout), .dout_oe(dout_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl              <= '0;
      ctrl[PM_HI:PM_LO] <= PM_NORMAL;
      track             <= 1'b1;
      stale             <= 1'b0;
    end else begin
      if (commit) ctrl <= ctl_word;
      if (cs_fall) stale <= ~conv_ok;
      if (cs_fall)         track <= 1'b0;
      else if (sleep)      track <= 1'b0;
      else if (track_edge) track <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_adc_port_chk.sv
module sar_adc_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic dout,
  input logic dout_oe,
  input logic track,
  input logic stale
);
  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  a_r1_reset_vals: assert property (@(posedge clk)
    rst |=> (track && !dout_oe && !stale))
    else $error("R1 reset values wrong");

  a_r10_float_idle: assert property (@(posedge clk) disable iff (rst)
    (armed && cs_n && $past(cs_n)) |-> !dout_oe)
    else $error("R10 output driven while chip select high");

  a_r6_hold_on_fall: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(cs_n)) |=> !track)
    else $error("R6 not in hold after frame start");

  a_r11_stale_steady: assert property (@(posedge clk) disable iff (rst)
    (armed && !$fell(cs_n)) |=> $stable(stale))
    else $error("R11 stale changed outside frame start");

  a_r2_lead_zero: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(dout_oe)) |-> !dout)
    else $error("R2 first bit not zero");
endmodule

bind sar_adc_port sar_adc_port_chk u_chk (.*);

// File: tb/sar_adc_port_test.sv
`timescale 1ns/1ps
module sar_adc_port_test;
  localparam int W = 24;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [11:0] s [4];
  logic [47:0] samples;
  logic dout, dout_oe, track, stale;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  assign samples = {s[3], s[2], s[1], s[0]};

  always #2 clk = ~clk;

  sar_adc_port #(.RES(12), .NCH(4), .WAKE_CYC(W)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .samples(samples), .dout(dout), .dout_oe(dout_oe),
    .track(track), .stale(stale)
  );

  // behavioural reference: state 0 on, 1 asleep, 2 waking
  logic [11:0] m_ctrl, m_sh;
  logic [15:0] m_word;
  int m_state, m_wake_at, m_cnt;
  bit m_oe, m_track, m_stale;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit eb;
    @(negedge clk);
    cyc++;
    if (m_state == 2 && cyc >= m_wake_at) m_state = 0;
    if (!rst) begin
      chk(dout_oe == m_oe, "R10 dout_oe", dout_oe, m_oe);
      chk(track == m_track, "R6 track", track, m_track);
      chk(stale == m_stale, "R11 stale", stale, m_stale);
      eb = (m_cnt < 16) ? m_word[15-m_cnt] : 1'b0;
      if (m_oe) chk(dout == eb, "R2 dout bit", dout, eb);
    end
  endtask

  task automatic m_fall_cs();
    bit ok, flt;
    logic [1:0] ch, pm;
    ch = m_ctrl[8:7];
    pm = m_ctrl[10:9];
    ok = (m_state == 0);
    flt = (m_state == 1) && (pm != 2'b01);
    if (m_state == 1 && pm == 2'b01) begin
      m_state = 2;
      m_wake_at = cyc + W;
    end
    m_stale = !ok;
    m_word = {2'b00, ch, ok ? s[ch] : 12'h000};
    m_oe = !flt;
    m_track = 0;
    m_cnt = 0;
  endtask

  task automatic m_fall_sclk(input bit d);
    if (m_cnt < 12) m_sh = {m_sh[10:0], d};
    if (m_cnt == 13) m_track = 1;
    if (m_cnt == 15 && m_sh[11]) m_ctrl = m_sh;
    if (m_cnt < 16) m_cnt++;
  endtask

  task automatic m_rise_cs();
    int nxt;
    logic [1:0] pm;
    m_oe = 0;
    if (m_cnt == 16) begin
      pm = m_ctrl[10:9];
      nxt = m_state;
      if (pm == 2'b10) nxt = 1;
      else if (pm == 2'b01) begin
        if (!m_stale) nxt = 1;
      end else if (m_state == 1) begin
        nxt = 2;
        m_wake_at = cyc + W;
      end
      m_state = nxt;
      if (nxt == 1) m_track = 0;
    end
    m_cnt = 0;
  endtask

  task automatic frame(input logic [11:0] c, input int nedges,
                       output logic [15:0] rd, output bit seen);
    bit d;
    rd = '0;
    seen = 0;
    step(); cs_n = 0; m_fall_cs();
    repeat (3) step();
    for (int e = 0; e < nedges; e++) begin
      d = (e < 12) ? c[11-e] : 1'b0;
      din = d;
      repeat (2) step();
      rd[15-e] = dout;
      if (dout_oe) seen = 1;
      sclk = 0; m_fall_sclk(d);
      repeat (3) step();
      sclk = 1;
      step();
    end
    step(); cs_n = 1; m_rise_cs();
    repeat (4) step();
  endtask

  function automatic logic [11:0] cw(input bit w, input logic [1:0] pm, input logic [1:0] ch);
    return {w, pm, ch, 7'h00};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    bit seen;
    s[0] = 12'hA5C; s[1] = 12'h3F1; s[2] = 12'h800; s[3] = 12'hFFF;
    m_ctrl = {1'b0, 2'b11, 2'b00, 7'h00};
    m_sh = '0; m_word = '0; m_state = 0; m_wake_at = 0; m_cnt = 0;
    m_oe = 0; m_track = 1; m_stale = 0;
    repeat (5) step();
    rst = 0;
    step();
    chk(dout_oe == 0, "R1 dout_oe", dout_oe, 0);
    chk(track == 1, "R1 track", track, 1);
    chk(stale == 0, "R1 stale", stale, 0);

    frame(cw(1, 2'b11, 2'd2), 16, rd, seen);
    chk(rd == {4'b0000, s[0]}, "R2 channel 0 word", rd, {4'b0000, s[0]});
    chk(dout_oe == 0, "R10 idle after frame", dout_oe, 0);

    s[2] = 12'h19B;
    frame(cw(0, 2'b10, 2'd1), 16, rd, seen);
    chk(rd == {4'b0010, s[2]}, "R3 written channel 2", rd, {4'b0010, s[2]});

    frame(cw(0, 2'b10, 2'd1), 16, rd, seen);
    chk(rd == {4'b0010, s[2]}, "R4 write 0 ignored", rd, {4'b0010, s[2]});
    chk(stale == 0, "R4 still powered", stale, 0);

    frame(cw(1, 2'b11, 2'd3), 15, rd, seen);
    frame(cw(0, 2'b11, 2'd0), 16, rd, seen);
    chk(rd == {4'b0010, s[2]}, "R5 aborted write dropped", rd, {4'b0010, s[2]});
    chk(track == 1, "R6 tracking after frame", track, 1);

    frame(cw(1, 2'b10, 2'd1), 16, rd, seen);
    chk(rd == {4'b0010, s[2]}, "R7 last frame before sleep", rd, {4'b0010, s[2]});
    chk(track == 0, "R7 hold while asleep", track, 0);
    frame(cw(0, 2'b11, 2'd1), 16, rd, seen);
    chk(seen == 0, "R7 output floats asleep", seen, 0);
    chk(stale == 1, "R11 stale while asleep", stale, 1);

    frame(cw(1, 2'b11, 2'd1), 16, rd, seen);
    chk(seen == 0, "R7 wake frame floats", seen, 0);
    frame(cw(0, 2'b00, 2'd0), 16, rd, seen);
    chk(stale == 1, "R8 early frame stale", stale, 1);
    chk(rd == 16'h1000, "R8 early frame zero", rd, 16'h1000);
    repeat (60) step();
    frame(cw(0, 2'b00, 2'd0), 16, rd, seen);
    chk(stale == 0, "R8 frame after wake valid", stale, 0);
    chk(rd == {4'b0001, s[1]}, "R8 channel 1 word", rd, {4'b0001, s[1]});

    frame(cw(1, 2'b01, 2'd3), 16, rd, seen);
    chk(rd == {4'b0001, s[1]}, "R9 valid before auto sleep", rd, {4'b0001, s[1]});
    chk(track == 0, "R9 hold after auto sleep", track, 0);
    frame(cw(0, 2'b00, 2'd0), 16, rd, seen);
    chk(seen == 1, "R9 dummy frame driven", seen, 1);
    chk(stale == 1, "R9 dummy frame stale", stale, 1);
    chk(rd == 16'h3000, "R9 dummy frame zero", rd, 16'h3000);
    chk(track == 1, "R9 awake after dummy", track, 1);
    frame(cw(1, 2'b01, 2'd3), 16, rd, seen);
    chk(rd == {4'b0011, s[3]}, "R9 channel 3 word", rd, {4'b0011, s[3]});
    chk(stale == 0, "R11 valid clears stale", stale, 0);
    chk(track == 0, "R9 sleeps again", track, 0);

    repeat (10) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule